// File: doc/BRIEF.md
# Byte Alignment and Pixel Formatting Unit

This unit sits in a 64-bit SIMD media datapath and reshapes operand data in three ways. It can pull an 8-byte window out of two concatenated operands. It can interleave the low bytes of two operands. It can widen four 8-bit pixels into four 16-bit fixed-point lanes. The byte offset for the window comes from a small persistent offset register. Software-side logic loads this register through a plain write port. Every later window operation uses the loaded value until the next write.

Operations arrive on a valid/ready stream. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result appears on `out_data` with `out_valid` exactly one cycle later. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_valid` low or `out_ready` high). While `out_valid` is high and `out_ready` is low, the unit holds the result and refuses new work.

Top module: `pix_format_unit`

## Requirements
- R1: Opcode 0 (align) with offset k = 1..7 returns the first operand shifted left by 8*k bits, ORed with the second operand shifted right by 64-8*k bits.
- R2: Align with offset 0 returns the first operand unchanged; the second operand contributes nothing.
- R3: Opcode 1 (merge) places byte i of the first operand in output byte 2i+1 and byte i of the second operand in output byte 2i, for i = 0..3, where byte 0 is the least significant.
- R4: Merge ignores bytes 4..7 of both operands.
- R5: Opcode 2 (expand) takes byte i (i = 0..3) of the first operand's low 32 bits, zero-extends it, shifts it left by 4, and places it in 16-bit lane i of the result. The second operand is ignored.
- R6: A write to the offset register (`cfg_we` high) applies to align operations accepted in later cycles. An align accepted in the same cycle as the write uses the previous offset.
- R7: A result appears with `out_valid` high one cycle after acceptance. `out_valid` falls in the cycle after it is consumed, unless a new operation is accepted at the same time.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low. Otherwise `in_ready` is high.
- R9: Reset clears the offset register to 0 and drives `out_valid` low.
- R10: Opcode 3 is reserved and yields an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Offset register write enable |
| cfg_wdata | input | 3 | New byte offset |
| in_valid | input | 1 | Operation valid |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 2 | Opcode: 0 align, 1 merge, 2 expand, 3 reserved |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 64 | Registered result |

## Verification
Two things can happen in the same cycle: an offset write, and the acceptance of an align that reads the offset. The bench provokes this by raising `cfg_we` with a new offset on the same cycle it presents an align. It judges the result against the window at the old offset. It then issues a second align and expects the window at the new offset. The stall path also overlaps a held result with a pending input. That input must be taken only in the cycle `out_ready` returns, and the held value must not change before then.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef enum logic [1:0] {
    OP_ALIGN  = 2'd0,
    OP_MERGE  = 2'd1,
    OP_EXPAND = 2'd2,
    OP_RSVD   = 2'd3
  } fmt_op_e;
endpackage

// File: rtl/fmt_align.sv
module fmt_align #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8
) (
  input  logic [LANES*BYTE_W-1:0]    a,
  input  logic [LANES*BYTE_W-1:0]    b,
  input  logic [$clog2(LANES)-1:0]   offs,
  output logic [LANES*BYTE_W-1:0]    y
);
  localparam int DATA_W = LANES * BYTE_W;

  logic [2*DATA_W-1:0] joined;
  logic [2*DATA_W-1:0] shifted;

  // Upper half of {a,b} shifted by whole bytes; offset 0 leaves a untouched.
  always_comb begin
    joined  = {a, b};
    shifted = joined << (32'(offs) * BYTE_W);
    y       = shifted[2*DATA_W-1:DATA_W];
  end
endmodule

// File: rtl/fmt_merge.sv
module fmt_merge #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8
) (
  input  logic [LANES*BYTE_W/2-1:0] a_lo,
  input  logic [LANES*BYTE_W/2-1:0] b_lo,
  output logic [LANES*BYTE_W-1:0]   y
);
  localparam int HALF = LANES / 2;

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    assign y[(2*i+1)*BYTE_W +: BYTE_W] = a_lo[i*BYTE_W +: BYTE_W];
    assign y[(2*i)*BYTE_W   +: BYTE_W] = b_lo[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/fmt_expand.sv
module fmt_expand #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  parameter int SCALE  = 4
) (
  input  logic [LANES*BYTE_W/2-1:0] a_lo,
  output logic [LANES*BYTE_W-1:0]   y
);
  localparam int HALF   = LANES / 2;
  localparam int LANE_W = 2 * BYTE_W;
  localparam int TOP_Z  = LANE_W - BYTE_W - SCALE;

  for (genvar i = 0; i < HALF; i++) begin : g_lane
    assign y[i*LANE_W +: LANE_W] =
      {{TOP_Z{1'b0}}, a_lo[i*BYTE_W +: BYTE_W], {SCALE{1'b0}}};
  end
endmodule

// File: rtl/pix_format_unit.sv
module pix_format_unit
  import fmt_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  parameter int SCALE  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(LANES)-1:0]  cfg_wdata,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                in_op,
  input  logic [LANES*BYTE_W-1:0]   in_a,
  input  logic [LANES*BYTE_W-1:0]   in_b,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*BYTE_W-1:0]   out_data
);
  localparam int DATA_W = LANES * BYTE_W;
  localparam int HALF_W = DATA_W / 2;
  localparam int OFFS_W = $clog2(LANES);

  logic [OFFS_W-1:0] offs_q;
  logic [DATA_W-1:0] align_y, merge_y, expand_y, result;
  logic              fire;
  fmt_op_e           op;

  assign op       = fmt_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  // Offset register: a write lands at the edge, so a same-cycle align sees the old value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      offs_q <= '0;
    else if (cfg_we) offs_q <= cfg_wdata;
  end

  fmt_align #(.LANES(LANES), .BYTE_W(BYTE_W)) u_align (
    .a(in_a), .b(in_b), .offs(offs_q), .y(align_y)
  );

  fmt_merge #(.LANES(LANES), .BYTE_W(BYTE_W)) u_merge (
    .a_lo(in_a[HALF_W-1:0]), .b_lo(in_b[HALF_W-1:0]), .y(merge_y)
  );

  fmt_expand #(.LANES(LANES), .BYTE_W(BYTE_W), .SCALE(SCALE)) u_expand (
    .a_lo(in_a[HALF_W-1:0]), .y(expand_y)
  );

  always_comb begin
    unique case (op)
      OP_ALIGN:  result = align_y;
      OP_MERGE:  result = merge_y;
      OP_EXPAND: result = expand_y;
      default:   result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic [$clog2(LANES)-1:0] cfg_wdata,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [1:0]               in_op,
  input logic [LANES*BYTE_W-1:0]  in_a,
  input logic [LANES*BYTE_W-1:0]  in_b,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [LANES*BYTE_W-1:0]  out_data,
  input logic [$clog2(LANES)-1:0] offs_q
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !out_valid && offs_q == '0); // R9
  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n) acc |=> out_valid); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> offs_q == $past(cfg_wdata)); // R6
  AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 2'd0 && offs_q == '0 |=> out_data == $past(in_a)); // R2
  AST_MERGE_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 2'd1 |=> out_data[2*BYTE_W-1:BYTE_W] == $past(in_a[BYTE_W-1:0])
                             && out_data[BYTE_W-1:0] == $past(in_b[BYTE_W-1:0])); // R3
  AST_EXPAND_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 2'd2 |=> out_data[3:0] == 4'h0 && out_data[15:12] == 4'h0
                             && out_data[11:4] == $past(in_a[7:0])); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 2'd3 |=> out_data == '0); // R10
endmodule

bind pix_format_unit fmt_checker #(.LANES(LANES), .BYTE_W(BYTE_W)) u_fmt_chk (.*);

// File: tb/tb_pix_format_unit.sv
module tb_pix_format_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pix_format_unit dut (.*);

  localparam int NV = 9;
  localparam logic [63:0] A0 = 64'h0123456789ABCDEF;
  localparam logic [63:0] B0 = 64'hFEDCBA9876543210;
  // op, offset, a, b, expected, requirement number
  localparam logic [1:0]  V_OP [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3};
  localparam logic [2:0]  V_K  [NV] = '{3'd0, 3'd1, 3'd3, 3'd7, 3'd0, 3'd5, 3'd0, 3'd2, 3'd4};
  localparam logic [63:0] V_A  [NV] = '{A0, A0, A0, A0, A0, 64'hFFFFFFFF89ABCDEF, A0,
                                       64'h1111111100FF8001, A0};
  localparam logic [63:0] V_B  [NV] = '{B0, B0, B0, B0, B0, 64'hAAAAAAAA76543210, B0, B0, B0};
  localparam logic [63:0] V_E  [NV] = '{
    64'h0123456789ABCDEF,   // R2
    64'h23456789ABCDEFFE,   // R1
    64'h6789ABCDEFFEDCBA,   // R1
    64'hEFFEDCBA98765432,   // R1
    64'h8976AB54CD32EF10,   // R3
    64'h8976AB54CD32EF10,   // R4
    64'h08900AB00CD00EF0,   // R5
    64'h00000FF008000010,   // R5
    64'h0000000000000000};  // R10
  localparam int V_REQ [NV] = '{2, 1, 1, 1, 3, 4, 5, 5, 10};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] k);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = k;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R7: watchdog expired, actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R8 in_ready when empty", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // R9: offset cleared by reset, so align returns first operand
    issue(2'd0, A0, B0);
    chk("R9 align after reset", out_data, A0);
    chk("R7 valid after accept", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R7 valid drops after drain", 64'(out_valid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      write_cfg(V_K[i]);
      issue(V_OP[i], V_A[i], V_B[i]);
      chk($sformatf("R%0d vector %0d", V_REQ[i], i), out_data, V_E[i]);
    end

    // R6: write and align in same cycle use the old offset
    write_cfg(3'd3);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 3'd7;
    in_valid = 1'b1; in_op = 2'd0; in_a = A0; in_b = B0;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R6 same-cycle write uses old", out_data, 64'h6789ABCDEFFEDCBA);
    issue(2'd0, A0, B0);
    chk("R6 next align uses new", out_data, 64'hEFFEDCBA98765432);

    // R8: back-pressure hold and blocked input
    @(negedge clk);
    out_ready = 1'b0;
    issue(2'd1, A0, B0);
    chk("R8 held result", out_data, 64'h8976AB54CD32EF10);
    chk("R8 in_ready low when stalled", 64'(in_ready), 64'd0);
    in_valid = 1'b1; in_op = 2'd2; in_a = A0; in_b = B0;
    @(negedge clk);
    chk("R8 data stable under stall", out_data, 64'h8976AB54CD32EF10);
    chk("R8 valid stable under stall", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 pending taken after release", out_data, 64'h08900AB00CD00EF0);
    chk("R7 back-to-back valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R7 valid falls", 64'(out_valid), 64'd0);

    // R9: mid-run reset clears the offset
    write_cfg(3'd5);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    issue(2'd0, A0, B0);
    chk("R9 offset cleared by reset", out_data, A0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule